// File: doc/BRIEF.md
# ADC Master Serial Readout Controller

This block is the digital back end of a 16-bit sampling converter that acts as the serial master toward a host. A start pulse launches a conversion. The conversion is modelled as a countdown of a fixed number of system clock cycles. At the end of the countdown, the result is latched from a parallel input.

The block produces its own serial clock, a frame strobe and a serial data line. The serial clock is the system clock divided by an even ratio. Data changes while the non-inverted serial clock is low, and the host samples it on the rising edge.

A mode pin selects between two readout schedules:
- **Shift-after-convert:** the new result is sent as soon as the conversion ends, and busy stays high until the last bit has left.
- **Shift-during-convert:** the previously stored result is sent while the next conversion runs, and busy covers only the conversion.

Separate controls invert the serial clock and the frame strobe. A clock-source select input must be low for the block to act as the serial master.

Top module: `adc_serial_master`

## Requirements
- R1: After reset, busy is low, serial data is 0, and the serial clock and frame outputs sit at their idle levels. The idle level of each equals its invert control.
- R2: With the mode input low (0 = shift-after-convert), the block sends the value on the parallel input at the end of the countdown. The frame is 16 bits, most significant bit first, and the host samples each bit on a rising edge of the non-inverted serial clock.
- R3: In shift-after-convert mode, busy is high for CONV_CYCLES + 16*CLK_DIV cycles. It falls on the same edge on which the frame ends.
- R4: With the mode input high (1 = shift-during-convert), the frame starts on the clock after the start pulse and carries the result latched by the previous conversion. If no conversion has finished since reset, the frame carries all zeros.
- R5: In shift-during-convert mode, busy is high for exactly CONV_CYCLES cycles.
- R6: A start pulse is ignored while busy is high or while a frame is still shifting. Busy timing and frame content are then unchanged.
- R7: When its invert control is 1, the serial clock or the frame strobe is inverted, including its idle level.
- R8: A frame asserts the frame strobe for 16*CLK_DIV cycles and carries exactly 16 serial clock periods of CLK_DIV cycles each.
- R9: If the clock-source select is high when a conversion starts, no frame is produced. The result is still latched and is sent by a later shift-during-convert frame.
- R10: Serial data stays stable while the non-inverted serial clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion start pulse |
| sample_in | input | 16 | Parallel conversion result, latched at the end of the countdown |
| ext_sel | input | 1 | Clock-source select; 0 makes the block the serial master |
| read_mode | input | 1 | 0 = shift after convert, 1 = shift during convert |
| inv_sclk | input | 1 | Invert the serial clock output |
| inv_frame | input | 1 | Invert the frame strobe output |
| busy | output | 1 | Conversion (and, in shift-after-convert mode, readout) in progress |
| sclk | output | 1 | Serial clock output |
| frame | output | 1 | Frame strobe, asserted while serial data is valid |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with CLK_DIV = 6 and CONV_CYCLES = 50. With these values a frame (96 cycles) lasts longer than a conversion, so in shift-during-convert mode busy falls while bits are still shifting. This makes it possible to check that a start arriving after busy falls, but before the frame ends, is ignored. The divider ratio of 6 also exercises a serial clock period that is not a power of two.

// File: rtl/adc_serial_master.sv
module adc_serial_master #(
  parameter int CONV_CYCLES = 80,
  parameter int CLK_DIV     = 4,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              ext_sel,
  input  logic              read_mode,
  input  logic              inv_sclk,
  input  logic              inv_frame,
  output logic              busy,
  output logic              sclk,
  output logic              frame,
  output logic              sdata
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(CONV_CYCLES + 1);
  localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BW   = $clog2(DATA_W);

  logic              converting, mode_q, ext_q, shifting, hold_busy;
  logic [CW-1:0]     conv_cnt;
  logic [DW-1:0]     dcnt;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] last_q, shreg;

  wire accept      = start & ~busy & ~shifting;
  wire conv_done   = converting & (conv_cnt == '0);
  wire bit_end     = shifting & (dcnt == DW'(CLK_DIV - 1));
  wire frame_end   = bit_end & (bcnt == BW'(DATA_W - 1));
  wire launch_dur  = accept & read_mode & ~ext_sel;
  wire launch_aft  = conv_done & ~mode_q & ~ext_q;
  wire sclk_raw    = shifting & (dcnt >= DW'(HALF));

  assign busy  = converting | hold_busy;
  assign sclk  = sclk_raw ^ inv_sclk;
  assign frame = shifting ^ inv_frame;
  assign sdata = shifting & shreg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      converting <= 1'b0;
      conv_cnt   <= '0;
      mode_q     <= 1'b0;
      ext_q      <= 1'b0;
      last_q     <= '0;
    end else if (accept) begin
      converting <= 1'b1;
      conv_cnt   <= CW'(CONV_CYCLES - 1);
      mode_q     <= read_mode;
      ext_q      <= ext_sel;
    end else if (conv_done) begin
      converting <= 1'b0;
      last_q     <= sample_in;
    end else if (converting) begin
      conv_cnt   <= conv_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shifting  <= 1'b0;
      hold_busy <= 1'b0;
      shreg     <= '0;
      dcnt      <= '0;
      bcnt      <= '0;
    end else if (launch_dur) begin
      shifting  <= 1'b1;
      shreg     <= last_q;
      dcnt      <= '0;
      bcnt      <= '0;
    end else if (launch_aft) begin
      shifting  <= 1'b1;
      hold_busy <= 1'b1;
      shreg     <= sample_in;
      dcnt      <= '0;
      bcnt      <= '0;
    end else if (shifting) begin
      if (bit_end) begin
        dcnt  <= '0;
        bcnt  <= bcnt + 1'b1;
        shreg <= {shreg[DATA_W-2:0], 1'b0};
        if (frame_end) begin
          shifting  <= 1'b0;
          hold_busy <= 1'b0;
        end
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && conv_cnt != '0 && start) |=> (converting && conv_cnt == $past(conv_cnt) - 1'b1)); // R6
  AST_AFTER_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shifting) && $past(hold_busy)) |-> !busy); // R3
  AST_DURING_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(converting) && mode_q) |-> !busy); // R5
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_raw && $past(sclk_raw)) |-> $stable(sdata)); // R10
endmodule

// File: tb/adc_serial_master_test.sv
`timescale 1ns/1ps
module adc_serial_master_test;
  localparam int CONV = 50;
  localparam int DIV  = 6;
  localparam int FLEN = 16 * DIV;

  logic clk = 0, rst_n = 0, start = 0, ext_sel = 0, read_mode = 0;
  logic inv_sclk = 0, inv_frame = 0;
  logic [15:0] sample_in = '0;
  logic busy, sclk, frame, sdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_serial_master #(.CONV_CYCLES(CONV), .CLK_DIV(DIV), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_in(sample_in),
    .ext_sel(ext_sel), .read_mode(read_mode), .inv_sclk(inv_sclk),
    .inv_frame(inv_frame), .busy(busy), .sclk(sclk), .frame(frame), .sdata(sdata));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input bit mode, input bit ext, input bit is, input bit inf,
                          input logic [15:0] smp, input logic [15:0] exp_data,
                          input bit exp_frame, input int extra, input int exp_busy);
    int bcyc = 0, fcyc = 0, bits = 0;
    logic [15:0] data = '0;
    bit prev = 0, sn, fn;
    @(negedge clk);
    read_mode = mode; ext_sel = ext; inv_sclk = is; inv_frame = inf; sample_in = smp;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 1000; i++) begin
      start = (i == extra);
      sn = sclk ^ is;
      fn = frame ^ inf;
      if (busy) bcyc++;
      if (fn) fcyc++;
      if (fn && sn && !prev) begin
        data = {data[14:0], sdata};
        bits++;
      end
      prev = sn;
      if (!busy && !fn && i > extra) break;
      @(negedge clk);
    end
    start = 0;
    check(bcyc == exp_busy, mode ? "R5 busy length" : "R3 busy length", bcyc, exp_busy);
    check(fcyc == (exp_frame ? FLEN : 0), exp_frame ? "R8 frame length" : "R9 no frame", fcyc, exp_frame ? FLEN : 0);
    check(bits == (exp_frame ? 16 : 0), "R8 clock periods", bits, exp_frame ? 16 : 0);
    if (exp_frame)
      check(data == exp_data, mode ? "R4 frame data" : "R2 frame data", data, exp_data);
    check(sclk == is && frame == inf, "R7 idle levels", {sclk, frame}, {is, inf});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 0, "R1 busy", busy, 0);
    check(sdata == 0, "R1 sdata", sdata, 0);
    check(sclk == 0 && frame == 0, "R1 idle", {sclk, frame}, 0);
  endtask

  task automatic t_during_first();
    run_conv(1, 0, 0, 0, 16'h1234, 16'h0000, 1, -1, CONV);
  endtask

  task automatic t_during_blocked();
    // R6: start at cycle 70 lands after busy fell but while the frame is still shifting
    run_conv(1, 0, 0, 0, 16'hBEEF, 16'h1234, 1, 70, CONV);
  endtask

  task automatic t_after();
    // R6: start at cycle 10 lands while converting
    run_conv(0, 0, 0, 0, 16'hA5C3, 16'hA5C3, 1, 10, CONV + FLEN);
  endtask

  task automatic t_inverted();
    run_conv(0, 0, 1, 1, 16'h8001, 16'h8001, 1, -1, CONV + FLEN);
  endtask

  task automatic t_ext();
    run_conv(0, 1, 0, 0, 16'h0F0F, 16'h0000, 0, -1, CONV);
    run_conv(1, 0, 0, 0, 16'h7777, 16'h0F0F, 1, -1, CONV);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_during_first();
    t_during_blocked();
    t_after();
    t_inverted();
    t_ext();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule